// File: doc/BRIEF.md
# Strobed Output Delay Controller

This block decides when the outputs of a pulse-height window analyzer fire once a pulse has qualified. A one-cycle qualify pulse starts a timing episode. In internal-strobe operation the block counts out a programmable delay and then raises two logic pulses together: a wide slow pulse and a narrow fast pulse. In external-strobe operation the block instead opens an acceptance window. A rising edge on the strobe input inside that window fires both pulses at once. If the window runs out with no edge, the block drops back to idle, gives a one-cycle timeout flag and no output.

One range bit serves both paths. It picks the coarse delay span for the internal strobe and the window length for the external strobe. A fine value places the delay inside the chosen span. After the slow pulse ends, a recovery interval keeps the block busy. Qualify pulses that arrive while the block is busy are dropped and set a sticky overlap flag. All times are set in nanoseconds and turned into clock cycles from a clock-frequency parameter. The values below are for the default 250 MHz clock.

Top module: `sod_ctrl`

## Requirements
- R1: After reset, `slow_o`, `fast_o`, `busy_o`, `timeout_o` and `overlap_o` are all 0.
- R2: With `ext_sel_i`=0, a qualify taken at clock edge k raises `slow_o` and `fast_o` right after edge k+D. D = base + floor(min(fine,1000) × span / 1000). The spans are set by `hi_rng_i`: with 0, base 25 and span 250 cycles (100 ns to 1.1 µs); with 1, base 250 and span 2500 cycles (1 µs to 11 µs).
- R3: Both pulses start in the same cycle. `slow_o` stays high 125 cycles (500 ns) and `fast_o` stays high 5 cycles (20 ns).
- R4: With `ext_sel_i`=1, the window is W = 1250 cycles (5 µs) when `hi_rng_i`=0 and 12500 cycles (50 µs) when `hi_rng_i`=1. A rising `strb_i` sampled at edge k+j, with 1 ≤ j ≤ W, fires both pulses right after edge k+j.
- R5: If no strobe edge arrives by edge k+W, `busy_o` drops right after edge k+W, `timeout_o` is high for exactly that one cycle, and no pulse is produced.
- R6: Strobe edges have no effect in these cases: in internal mode; at the qualify edge itself; after the window has expired; and after the episode has already fired.
- R7: `busy_o` rises right after the qualify edge. After a fired episode it stays high for the wait cycles (D or j) plus 125 plus a 50-cycle (200 ns) recovery.
- R8: A qualify sampled while `busy_o` is high starts nothing and sets `overlap_o`, which stays 1 until reset. A qualify sampled once `busy_o` is low is taken.
- R9: `ext_sel_i`, `hi_rng_i` and `fine_i` are latched when the qualify is taken. Changes to them during an episode do not alter its timing.
- R10: Fine values above 1000 act as 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qual_i | input | 1 | Qualify pulse: one per accepted event |
| ext_sel_i | input | 1 | 0 = internal delay, 1 = external strobe |
| hi_rng_i | input | 1 | 0 = short range, 1 = long range |
| fine_i | input | FINE_W | Fine delay position, 0..1000 |
| strb_i | input | 1 | External strobe, rising edge used |
| slow_o | output | 1 | Wide output pulse |
| fast_o | output | 1 | Narrow output pulse |
| busy_o | output | 1 | Episode in progress |
| timeout_o | output | 1 | One-cycle flag on window expiry |
| overlap_o | output | 1 | Sticky: qualify seen while busy |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that the pulse widths and the recovery are at least one cycle, and that the slow width is no shorter than the fast width. With those conditions met, the outputs can only rise out of a busy state, and a timeout can never coincide with an output. The stimulus changes inputs only on falling edges. It drives qualify as single-cycle pulses. It holds each strobe low before its intended rising edge so that exactly one edge is seen. It also places strobe edges on both sides of the window limit and inside the firing interval.

// File: rtl/sod_pkg.sv
package sod_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_FIRE,
        ST_REC
    } sod_state_e;

    typedef struct packed {
        logic ext_sel;
        logic hi_rng;
    } sod_cfg_t;

    // nanoseconds to whole clock cycles at the given clock in MHz
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned mhz);
        return (ns * mhz) / 1000;
    endfunction

    function automatic int unsigned maxu(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sod_edge.sv
module sod_edge (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic rise_o
);
    logic d_q;

    always_ff @(posedge clk) begin
        if (rst) d_q <= 1'b0;
        else     d_q <= d_i;
    end

    assign rise_o = d_i & ~d_q;

endmodule

// File: rtl/sod_span.sv
module sod_span
    import sod_pkg::*;
#(
    parameter int unsigned FINE_W    = 10,
    parameter int unsigned FINE_FULL = 1000,
    parameter int unsigned CNT_W     = 14,
    parameter int unsigned LO_BASE   = 25,
    parameter int unsigned LO_SPAN   = 250,
    parameter int unsigned HI_BASE   = 250,
    parameter int unsigned HI_SPAN   = 2500,
    parameter int unsigned WIN_LO    = 1250,
    parameter int unsigned WIN_HI    = 12500
) (
    input  sod_cfg_t          cfg_i,
    input  logic [FINE_W-1:0] fine_i,
    output logic [CNT_W-1:0]  limit_o
);
    localparam int unsigned PW       = FINE_W + CNT_W;
    localparam bit          FULL_POW2 = ((FINE_FULL & (FINE_FULL - 1)) == 0);

    logic [FINE_W-1:0] fine_c;
    logic [CNT_W-1:0]  base;
    logic [CNT_W-1:0]  span;
    logic [PW-1:0]     prod;
    logic [PW-1:0]     frac;

    always_comb begin
        fine_c = (fine_i > FINE_W'(FINE_FULL)) ? FINE_W'(FINE_FULL) : fine_i;
        base   = cfg_i.hi_rng ? CNT_W'(HI_BASE) : CNT_W'(LO_BASE);
        span   = cfg_i.hi_rng ? CNT_W'(HI_SPAN) : CNT_W'(LO_SPAN);
        prod   = PW'(fine_c) * PW'(span);
    end

    // full-scale of a power of two scales by shifting, otherwise by division
    generate
        if (FULL_POW2) begin : g_shift
            assign frac = prod >> $clog2(FINE_FULL);
        end else begin : g_div
            assign frac = prod / PW'(FINE_FULL);
        end
    endgenerate

    always_comb begin
        if (cfg_i.ext_sel)
            limit_o = cfg_i.hi_rng ? CNT_W'(WIN_HI) : CNT_W'(WIN_LO);
        else
            limit_o = CNT_W'(PW'(base) + frac);
    end

endmodule

// File: rtl/sod_ctrl.sv
module sod_ctrl
    import sod_pkg::*;
#(
    parameter int unsigned CLK_MHZ    = 250,
    parameter int unsigned FINE_W     = 10,
    parameter int unsigned FINE_FULL  = 1000,
    parameter int unsigned LO_BASE_NS = 100,
    parameter int unsigned LO_SPAN_NS = 1000,
    parameter int unsigned HI_BASE_NS = 1000,
    parameter int unsigned HI_SPAN_NS = 10000,
    parameter int unsigned WIN_LO_NS  = 5000,
    parameter int unsigned WIN_HI_NS  = 50000,
    parameter int unsigned SLOW_NS    = 500,
    parameter int unsigned FAST_NS    = 20,
    parameter int unsigned REC_NS     = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              qual_i,
    input  logic              ext_sel_i,
    input  logic              hi_rng_i,
    input  logic [FINE_W-1:0] fine_i,
    input  logic              strb_i,
    output logic              slow_o,
    output logic              fast_o,
    output logic              busy_o,
    output logic              timeout_o,
    output logic              overlap_o
);
    localparam int unsigned LO_BASE = ns2cyc(LO_BASE_NS, CLK_MHZ);
    localparam int unsigned LO_SPAN = ns2cyc(LO_SPAN_NS, CLK_MHZ);
    localparam int unsigned HI_BASE = ns2cyc(HI_BASE_NS, CLK_MHZ);
    localparam int unsigned HI_SPAN = ns2cyc(HI_SPAN_NS, CLK_MHZ);
    localparam int unsigned WIN_LO  = ns2cyc(WIN_LO_NS, CLK_MHZ);
    localparam int unsigned WIN_HI  = ns2cyc(WIN_HI_NS, CLK_MHZ);
    localparam int unsigned SLOW_C  = ns2cyc(SLOW_NS, CLK_MHZ);
    localparam int unsigned FAST_C  = ns2cyc(FAST_NS, CLK_MHZ);
    localparam int unsigned REC_C   = ns2cyc(REC_NS, CLK_MHZ);
    localparam int unsigned MAX_C   = maxu(maxu(WIN_HI, WIN_LO),
                                           maxu(maxu(HI_BASE + HI_SPAN, LO_BASE + LO_SPAN),
                                                maxu(SLOW_C, REC_C)));
    localparam int unsigned CNT_W   = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] ONE = 1;

    sod_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] limit_w;
    logic             ext_q;
    logic             strb_rise;
    logic             at_limit;
    sod_cfg_t         cfg_w;

    assign cfg_w = '{ext_sel: ext_sel_i, hi_rng: hi_rng_i};

    sod_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .d_i    (strb_i),
        .rise_o (strb_rise)
    );

    sod_span #(
        .FINE_W    (FINE_W),
        .FINE_FULL (FINE_FULL),
        .CNT_W     (CNT_W),
        .LO_BASE   (LO_BASE),
        .LO_SPAN   (LO_SPAN),
        .HI_BASE   (HI_BASE),
        .HI_SPAN   (HI_SPAN),
        .WIN_LO    (WIN_LO),
        .WIN_HI    (WIN_HI)
    ) u_span (
        .cfg_i   (cfg_w),
        .fine_i  (fine_i),
        .limit_o (limit_w)
    );

    assign at_limit = (cnt == limit_q - ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            limit_q   <= '0;
            ext_q     <= 1'b0;
            slow_o    <= 1'b0;
            fast_o    <= 1'b0;
            timeout_o <= 1'b0;
            overlap_o <= 1'b0;
        end else begin
            timeout_o <= 1'b0;
            if (qual_i && state != ST_IDLE) overlap_o <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (qual_i) begin
                        state   <= ST_WAIT;
                        cnt     <= '0;
                        limit_q <= limit_w;
                        ext_q   <= cfg_w.ext_sel;
                    end
                end
                ST_WAIT: begin
                    if (ext_q ? strb_rise : at_limit) begin
                        state  <= ST_FIRE;
                        cnt    <= '0;
                        slow_o <= 1'b1;
                        fast_o <= 1'b1;
                    end else if (ext_q && at_limit) begin
                        state     <= ST_IDLE;
                        cnt       <= '0;
                        timeout_o <= 1'b1;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                ST_FIRE: begin
                    cnt <= cnt + ONE;
                    if (cnt == CNT_W'(FAST_C - 1)) fast_o <= 1'b0;
                    if (cnt == CNT_W'(SLOW_C - 1)) begin
                        slow_o <= 1'b0;
                        state  <= ST_REC;
                        cnt    <= '0;
                    end
                end
                default: begin
                    if (cnt == CNT_W'(REC_C - 1)) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
            endcase
        end
    end

    assign busy_o = (state != ST_IDLE);

    // R3
    fast_within_slow_chk: assert property (@(posedge clk) disable iff (rst)
        fast_o |-> slow_o);

    // R3
    pulses_together_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(slow_o) |-> fast_o);

    // R5
    timeout_silent_chk: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> (!busy_o && !slow_o && !fast_o));

    // R7
    busy_covers_out_chk: assert property (@(posedge clk) disable iff (rst)
        (slow_o || fast_o) |-> busy_o);

    // R7
    take_qualify_chk: assert property (@(posedge clk) disable iff (rst)
        (qual_i && !busy_o) |=> busy_o);

    // R6
    no_fire_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(slow_o) |-> $past(busy_o));

    // R8
    overlap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overlap_o |=> overlap_o);

endmodule

// File: tb/sim_sod_ctrl.sv
module sim_sod_ctrl;
    localparam int MHZ    = 250;
    localparam int SLOW_C = 125;
    localparam int FAST_C = 5;
    localparam int REC_C  = 50;
    localparam int K_FIRE = 0;
    localparam int K_TMO  = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       qual = 1'b0, ext_sel = 1'b0, hi_rng = 1'b0, strb = 1'b0;
    logic [9:0] fine = '0;
    logic       slow_o, fast_o, busy_o, timeout_o, overlap_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    int    exp_kind[$];
    int    exp_cyc[$];
    string exp_tag[$];

    always #2 clk = ~clk;

    sod_ctrl u0 (
        .clk(clk), .rst(rst), .qual_i(qual), .ext_sel_i(ext_sel),
        .hi_rng_i(hi_rng), .fine_i(fine), .strb_i(strb),
        .slow_o(slow_o), .fast_o(fast_o), .busy_o(busy_o),
        .timeout_o(timeout_o), .overlap_o(overlap_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int dly(input bit hi, input int f);
        int fc = (f > 1000) ? 1000 : f;
        int base = (hi ? 1000 : 100) * MHZ / 1000;
        int span = (hi ? 10000 : 1000) * MHZ / 1000;
        return base + (fc * span) / 1000;
    endfunction

    task automatic push(input int kind, input int c, input string tag);
        exp_kind.push_back(kind);
        exp_cyc.push_back(c);
        exp_tag.push_back(tag);
    endtask

    task automatic pop_cmp(input int kind);
        if (exp_kind.size() == 0) begin
            chk(0, (kind == K_FIRE) ? "R6 unexpected output" : "R5 unexpected timeout", cyc, -1);
        end else begin
            int k = exp_kind.pop_front();
            int c = exp_cyc.pop_front();
            string t = exp_tag.pop_front();
            chk(k == kind, t, kind, k);
            chk(c == cyc, t, cyc, c);
        end
    endtask

    // monitor: sampled on falling edges
    int  rise_s = 0, rise_f = 0;
    bit  slow_p = 0, fast_p = 0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (slow_o && !slow_p) begin
                rise_s = cyc;
                pop_cmp(K_FIRE);
                chk(fast_o == 1'b1, "R3 fast with slow", int'(fast_o), 1);
            end
            if (!slow_o && slow_p) chk(cyc - rise_s == SLOW_C, "R3 slow width", cyc - rise_s, SLOW_C);
            if (fast_o && !fast_p) rise_f = cyc;
            if (!fast_o && fast_p) chk(cyc - rise_f == FAST_C, "R3 fast width", cyc - rise_f, FAST_C);
            if (timeout_o) pop_cmp(K_TMO);
            slow_p = slow_o;
            fast_p = fast_o;
        end
    end

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic pulse_strb_at(input int c);
        wait_to(c);
        strb = 1'b1;
        @(negedge clk);
        @(negedge clk);
        strb = 1'b0;
    endtask

    // driver: one episode; j = strobe offset in edges (0 = with the qualify)
    task automatic shot(input bit ext, input bit hi, input int f, input int j,
                        input bit perturb, input int ovl_at, input string tag);
        int qe, total, w;
        @(negedge clk);
        ext_sel = ext; hi_rng = hi; fine = 10'(f);
        qual = 1'b1;
        if (ext && j == 0) strb = 1'b1;
        qe = cyc + 1;
        w = hi ? 12500 : 1250;
        if (!ext) begin
            total = dly(hi, f) + SLOW_C + REC_C;
            push(K_FIRE, qe + dly(hi, f), {tag, " fire cycle"});
        end else if (j >= 1 && j <= w) begin
            total = j + SLOW_C + REC_C;
            push(K_FIRE, qe + j, {tag, " strobe fire cycle"});
        end else begin
            total = w;
            push(K_TMO, qe + w, {tag, " timeout cycle"});
        end
        @(negedge clk);
        qual = 1'b0;
        chk(busy_o == 1'b1, "R7 busy after qualify", int'(busy_o), 1);
        if (perturb) begin
            hi_rng = ~hi; fine = ~fine; ext_sel = ~ext;
        end
        if (ext && j == 0) begin
            @(negedge clk);
            @(negedge clk);
            strb = 1'b0;
        end
        if (!ext && perturb) pulse_strb_at(qe + 3);
        if (ovl_at > 0) begin
            wait_to(qe + ovl_at - 1);
            qual = 1'b1;
            @(negedge clk);
            qual = 1'b0;
            chk(overlap_o == 1'b1, "R8 overlap set", int'(overlap_o), 1);
        end
        if (ext && j >= 1 && j <= w) begin
            pulse_strb_at(qe + j - 1);
            pulse_strb_at(qe + j + 20);
        end
        wait_to(qe + total - 1);
        chk(busy_o == 1'b1, "R7 busy last cycle", int'(busy_o), 1);
        @(negedge clk);
        chk(busy_o == 1'b0, "R7 busy released", int'(busy_o), 0);
        if (ext && j > w) begin
            pulse_strb_at(qe + w + 2);
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(slow_o == 1'b0, "R1 slow", int'(slow_o), 0);
        chk(fast_o == 1'b0, "R1 fast", int'(fast_o), 0);
        chk(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
        chk(timeout_o == 1'b0, "R1 timeout", int'(timeout_o), 0);
        chk(overlap_o == 1'b0, "R1 overlap", int'(overlap_o), 0);

        shot(0, 0, 0,    0, 0, 0, "R2 low fine 0");
        shot(0, 0, 600,  0, 0, 0, "R2 low fine 600");
        shot(0, 1, 333,  0, 0, 0, "R2 high fine 333");
        shot(0, 0, 1023, 0, 0, 0, "R10 clamp low");
        shot(0, 1, 1000, 0, 1, 0, "R9 latched R6 strobe in internal");
        chk(overlap_o == 1'b0, "R8 no overlap yet", int'(overlap_o), 0);
        shot(1, 0, 0,    1,    0, 0, "R4 low first edge");
        shot(1, 0, 500,  1250, 0, 0, "R4 low last edge");
        shot(1, 0, 0,    1251, 0, 0, "R5 low expiry");
        shot(1, 0, 0,    0,    0, 0, "R6 strobe at qualify");
        shot(1, 1, 7,    9000, 1, 0, "R4 high window");
        shot(1, 1, 0,    13000,0, 0, "R5 high expiry");
        shot(0, 0, 0,    0, 0, 10, "R8 overlap ignored");
        shot(0, 0, 4,    0, 0, 0, "R8 retaken after idle");

        repeat (10) @(negedge clk);
        chk(exp_kind.size() == 0, "R6 pending expectations", exp_kind.size(), 0);
        chk(overlap_o == 1'b1, "R8 overlap sticky", int'(overlap_o), 1);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule